// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is a debug trigger that counts retired instructions and requests a breakpoint exception once a programmed number of them has retired. Software loads a control word that holds a 14-bit remaining count and a set of per-privilege enable bits. Every time the core reports a retired instruction while running in a privilege mode whose enable bit is set, the remaining count drops by one. When it reaches zero, the block pulses a breakpoint request for one cycle and then stays inactive until software loads a new count.

Non-virtualised execution is gated by the user, supervisor and machine enables. Virtualised execution is gated by two separate enables for virtual user and virtual supervisor. The control word reads back with the live remaining count in place, so a debugger can watch the count fall.

Behaviour is driven by a three-state machine. IDLE means the count is zero and nothing happens. ARMED means the count is nonzero and enabled retires decrement it. FIRE lasts one cycle and drives the breakpoint request. The transitions are as follows:
- A write with a nonzero count goes to ARMED.
- A write with a zero count goes to IDLE.
- An enabled retire while the count is 1 goes from ARMED to FIRE.
- FIRE always goes to IDLE on the next cycle, unless a write in that cycle moves it elsewhere.
- A write takes priority over every other transition.

Top module: `icount_trigger`

## Requirements
- R1: After reset the control readback is all zeros and the breakpoint request is low.
- R2: A control write keeps only the following bits; every other bit, including action, hit and pending, reads back as zero:
  - the count in bits 23:10
  - U at bit 6, S at bit 7 and M at bit 9
  - VU at bit 25 and VS at bit 26
- R3: When not virtualised, a retire decrements the count only if the enable for the current privilege is set. The privilege codes are 0 for U, 1 for S and 3 for M; U uses bit 6, S uses bit 7 and M uses bit 9. Privilege code 2 never counts.
- R4: When virtualised, a retire at privilege 0 counts only if VU (bit 25) is set, and a retire at privilege 1 counts only if VS (bit 26) is set. Privilege 3 never counts when virtualised. The non-virtual enables have no effect in this case.
- R5: A retire in a privilege mode that is not enabled leaves the count unchanged.
- R6: With a count of zero, retires change nothing and no breakpoint request is raised.
- R7: An enabled retire at count 1 makes the count 0. The breakpoint request is high for exactly the following cycle. The count then stays at 0 under further retires.
- R8: A control write in the same cycle as an enabled retire loads the written count, and no decrement is applied.
- R9: The readback shows the live remaining count in bits 23:10 on the cycle after each update.
- R10: Each cycle with the retire strobe high applies at most one decrement. A strobe held for N cycles removes N from the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word to write |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt | input | 1 | Hart is running virtualised |
| ctrl_rd | output | 32 | Control readback with live count |
| bp_req | output | 1 | One-cycle breakpoint-exception request |

## Verification
The counting path is tried with a table that pairs every privilege code with both values of the virtualisation flag, under enable sets that match the current mode, match only a neighbouring mode, or match only the other (virtual or non-virtual) group. A single retire after each fresh load shows whether the gate picked the right enable bit. Directed cases then separate the following behaviours:
- a held strobe (multiple decrements) from a single one;
- a count of one (pulse) from a count of zero (silence);
- a write racing a retire.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } icnt_state_e;

    typedef struct packed {
        logic vs;
        logic vu;
        logic m;
        logic s;
        logic u;
    } icnt_en_t;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/icnt_wr_filter.sv
module icnt_wr_filter
    import icnt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14,
    parameter int U_BIT   = 6,
    parameter int S_BIT   = 7,
    parameter int M_BIT   = 9,
    parameter int VU_BIT  = 25,
    parameter int VS_BIT  = 26
) (
    input  logic [XLEN-1:0]  raw,
    output logic [XLEN-1:0]  kept,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [XLEN-1:0] CNT_MASK = ((XLEN'(1) << CNT_W) - XLEN'(1)) << CNT_LSB;
    localparam logic [XLEN-1:0] EN_MASK  = (XLEN'(1) << U_BIT)  | (XLEN'(1) << S_BIT) |
                                           (XLEN'(1) << M_BIT)  | (XLEN'(1) << VU_BIT) |
                                           (XLEN'(1) << VS_BIT);
    localparam logic [XLEN-1:0] KEEP_MASK = CNT_MASK | EN_MASK;

    always_comb begin
        kept = raw & KEEP_MASK;
        cnt  = kept[CNT_LSB +: CNT_W];
    end
endmodule

// File: rtl/icnt_priv_gate.sv
module icnt_priv_gate
    import icnt_pkg::*;
(
    input  icnt_en_t   en,
    input  logic [1:0] priv,
    input  logic       virt,
    output logic       count_ok
);
    always_comb begin
        count_ok = 1'b0;
        if (virt) begin
            unique case (priv)
                PRIV_U:  count_ok = en.vu;
                PRIV_S:  count_ok = en.vs;
                default: count_ok = 1'b0;
            endcase
        end else begin
            unique case (priv)
                PRIV_U:  count_ok = en.u;
                PRIV_S:  count_ok = en.s;
                PRIV_M:  count_ok = en.m;
                default: count_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/icnt_count_fsm.sv
module icnt_count_fsm
    import icnt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             retire,
    input  logic             count_ok,
    output logic [CNT_W-1:0] cnt,
    output logic             bp_req
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    icnt_state_e      st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= CNT_ZERO;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (wr_en) begin
            cnt_nxt = wr_cnt;
            st_nxt  = (wr_cnt != CNT_ZERO) ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_nxt = ST_IDLE;
                end
                ST_ARMED: begin
                    if (retire && count_ok) begin
                        cnt_nxt = cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) begin
                            st_nxt = ST_FIRE;
                        end
                    end
                end
                ST_FIRE: begin
                    st_nxt = ST_IDLE;
                end
                default: begin
                    st_nxt = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        cnt    = cnt_q;
        bp_req = (st_q == ST_FIRE);
    end

    assert_armed_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED) |-> (cnt_q != CNT_ZERO));

    assert_zero_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_q == CNT_ZERO) |=> (cnt_q == CNT_ZERO));

    assert_gated_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(retire && count_ok)) |=> $stable(cnt_q));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && retire && count_ok && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_cnt)));

    assert_pulse_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |=> !bp_req);

    assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> (cnt_q == CNT_ZERO));
endmodule

// File: rtl/icount_trigger.sv
module icount_trigger
    import icnt_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CNT_LSB = 10,
    parameter int CNT_W   = 14,
    parameter int U_BIT   = 6,
    parameter int S_BIT   = 7,
    parameter int M_BIT   = 9,
    parameter int VU_BIT  = 25,
    parameter int VS_BIT  = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            retire,
    input  logic [1:0]      priv,
    input  logic            virt,
    output logic [XLEN-1:0] ctrl_rd,
    output logic            bp_req
);
    localparam logic [XLEN-1:0] CNT_FIELD = ((XLEN'(1) << CNT_W) - XLEN'(1)) << CNT_LSB;

    logic [XLEN-1:0]  kept_w;
    logic [CNT_W-1:0] wr_cnt_w;
    logic [XLEN-1:0]  ctrl_q;
    logic [CNT_W-1:0] live_cnt;
    icnt_en_t         en_w;
    logic             count_ok_w;

    icnt_wr_filter #(
        .XLEN(XLEN), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W),
        .U_BIT(U_BIT), .S_BIT(S_BIT), .M_BIT(M_BIT),
        .VU_BIT(VU_BIT), .VS_BIT(VS_BIT)
    ) u_filter (
        .raw  (wr_data),
        .kept (kept_w),
        .cnt  (wr_cnt_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= kept_w;
        end
    end

    always_comb begin
        en_w.u  = ctrl_q[U_BIT];
        en_w.s  = ctrl_q[S_BIT];
        en_w.m  = ctrl_q[M_BIT];
        en_w.vu = ctrl_q[VU_BIT];
        en_w.vs = ctrl_q[VS_BIT];
    end

    icnt_priv_gate u_gate (
        .en       (en_w),
        .priv     (priv),
        .virt     (virt),
        .count_ok (count_ok_w)
    );

    icnt_count_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_cnt   (wr_cnt_w),
        .retire   (retire),
        .count_ok (count_ok_w),
        .cnt      (live_cnt),
        .bp_req   (bp_req)
    );

    always_comb begin
        ctrl_rd = (ctrl_q & ~CNT_FIELD) | (XLEN'(live_cnt) << CNT_LSB);
    end

    assert_keep_u_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_rd[U_BIT] == $past(wr_data[U_BIT])));

    assert_keep_vs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_rd[VS_BIT] == $past(wr_data[VS_BIT])));

    assert_virt_m_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && virt && priv == PRIV_M) |=> $stable(ctrl_rd));
endmodule

// File: tb/sim_icount_trigger.sv
module sim_icount_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        retire = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic [31:0] ctrl_rd;
    logic        bp_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    icount_trigger u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .retire(retire), .priv(priv), .virt(virt), .ctrl_rd(ctrl_rd), .bp_req(bp_req)
    );

    // entry: {virt, priv[1:0], en{vs,vu,m,s,u}, expect_decrement}
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 2'd0, 5'b00001, 1'b1},
        {1'b0, 2'd0, 5'b00110, 1'b0},
        {1'b0, 2'd1, 5'b00010, 1'b1},
        {1'b0, 2'd1, 5'b11101, 1'b0},
        {1'b0, 2'd3, 5'b00100, 1'b1},
        {1'b0, 2'd3, 5'b11011, 1'b0},
        {1'b0, 2'd2, 5'b11111, 1'b0},
        {1'b1, 2'd0, 5'b01000, 1'b1},
        {1'b1, 2'd0, 5'b10111, 1'b0},
        {1'b1, 2'd1, 5'b10000, 1'b1},
        {1'b1, 2'd1, 5'b01111, 1'b0},
        {1'b1, 2'd3, 5'b11111, 1'b0},
        {1'b1, 2'd2, 5'b11111, 1'b0},
        {1'b0, 2'd0, 5'b11000, 1'b0},
        {1'b0, 2'd1, 5'b11111, 1'b1},
        {1'b1, 2'd0, 5'b11111, 1'b1}
    };

    function automatic logic [31:0] mk(input int cnt, input logic [4:0] en);
        logic [31:0] w;
        w = 32'(cnt & 16'h3FFF) << 10;
        w[6]  = en[0];
        w[7]  = en[1];
        w[9]  = en[2];
        w[25] = en[3];
        w[26] = en[4];
        return w;
    endfunction

    function automatic int rd_cnt(input logic [31:0] w);
        return int'((w >> 10) & 32'h3FFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_retire(input logic [1:0] p, input logic v, input int n);
        priv = p;
        virt = v;
        retire = 1'b1;
        repeat (n) @(negedge clk);
        retire = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 readback", ctrl_rd, 32'h0);
        chk("R1 bp_req", 32'(bp_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R9: table walk, one retire after each fresh load of 5
        for (int i = 0; i < NV; i++) begin
            do_write(mk(5, VEC[i][5:1]));
            do_retire(VEC[i][7:6], VEC[i][8], 1);
            chk($sformatf("R3/R4/R5/R9 vec%0d count", i),
                32'(rd_cnt(ctrl_rd)), 32'(VEC[i][0] ? 4 : 5));
            chk($sformatf("R3/R4/R5 vec%0d bp", i), 32'(bp_req), 32'h0);
        end

        // R2: only the kept fields survive a write of all ones
        do_write(32'hFFFF_FFFF);
        chk("R2 keep mask", ctrl_rd,
            (32'h3FFF << 10) | (32'h1 << 6) | (32'h1 << 7) | (32'h1 << 9) |
            (32'h1 << 25) | (32'h1 << 26));

        // R6: zero count ignores retires
        do_write(mk(0, 5'b11111));
        do_retire(2'd3, 1'b0, 4);
        chk("R6 count", 32'(rd_cnt(ctrl_rd)), 32'd0);
        chk("R6 bp", 32'(bp_req), 32'h0);

        // R10: held strobe, one decrement per cycle
        do_write(mk(3, 5'b00100));
        do_retire(2'd3, 1'b0, 2);
        chk("R10 count", 32'(rd_cnt(ctrl_rd)), 32'd1);
        chk("R10 bp", 32'(bp_req), 32'h0);

        // R7: final retire fires a single-cycle pulse, count stays 0
        priv = 2'd3; virt = 1'b0; retire = 1'b1;
        @(negedge clk);
        chk("R7 count zero", 32'(rd_cnt(ctrl_rd)), 32'd0);
        chk("R7 pulse high", 32'(bp_req), 32'h1);
        @(negedge clk);
        chk("R7 pulse low", 32'(bp_req), 32'h0);
        @(negedge clk);
        retire = 1'b0;
        chk("R7 stays zero", 32'(rd_cnt(ctrl_rd)), 32'd0);
        chk("R7 no repulse", 32'(bp_req), 32'h0);

        // R8: write beats simultaneous retire
        do_write(mk(3, 5'b00100));
        wr_en = 1'b1; wr_data = mk(9, 5'b00100);
        priv = 2'd3; virt = 1'b0; retire = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; retire = 1'b0;
        chk("R8 count", 32'(rd_cnt(ctrl_rd)), 32'd9);
        chk("R8 bp", 32'(bp_req), 32'h0);

        // R8: write of 1 racing a retire at count 1 gives no pulse
        do_write(mk(1, 5'b00100));
        wr_en = 1'b1; wr_data = mk(1, 5'b00100); retire = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; retire = 1'b0;
        chk("R8 reload count", 32'(rd_cnt(ctrl_rd)), 32'd1);
        chk("R8 reload bp", 32'(bp_req), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule